// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register face of a three-channel interval timer. A host reaches it through four addresses: addresses 0, 1 and 2 carry count bytes for channels 0, 1 and 2, and address 3 takes control words. The block decodes each control word into a channel's access mode, counting mode and BCD flag. It steps through the byte order of count writes and reads, and it keeps a count snapshot and a status snapshot for each channel. It does no counting of its own. When a complete count has been written, it pulses a per-channel load strobe with the 16-bit value. It samples each channel's live count and output level whenever a snapshot is taken or a live read is made.

A host programs a channel by writing a control word and then one or two count bytes. It reads back by issuing a count latch, a status latch or a combined read-back command, followed by data-port reads. Read data is combinational while a read is presented. The side effects of the read (releasing a latch, advancing the byte order) take place at the clock edge that ends the access.

Top module: `tmr_bus_front`

## Requirements
- R1: A write to address 3 is a control word: bits 7:6 select the channel (0..2), bits 5:4 the access mode (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the counting mode and bit 0 BCD. A nonzero access mode stores these in the channel and shows them on `chanMode`/`chanBcd`. Counting modes 6 and 7 are stored as 2 and 3.
- R2: In low-only mode, a data write pulses that channel's `loadStb` for one cycle, in the cycle after the write, with `loadCount` = {8'h00, byte}.
- R3: In high-only mode, a data write loads {byte, 8'h00} with the same timing.
- R4: In low-then-high mode, the first data byte is held and produces no strobe. The second byte strobes a load of {second, first}. At most one channel strobes in any cycle.
- R5: A control word with access mode 0 snapshots the selected channel's live count. Reads then return it as the access mode dictates: in low-then-high mode the low byte comes first, and the snapshot is released only after the high byte.
- R6: A count or status latch request is ignored while that channel still holds an unread latch of the same kind.
- R7: Select value 3 is a read-back command: bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 low requests a count latch and bit 4 low requests a status latch for every picked channel.
- R8: The status byte holds the output level in bit 7, the null-count flag in bit 6, the access mode in bits 5:4, the counting mode in bits 3:1 and BCD in bit 0. Null-count is set by a control word with nonzero access mode and cleared by the load that completes a count.
- R9: A data-port read returns a pending status first, then a pending count snapshot, and only then the live count.
- R10: Unlatched reads in low-then-high mode alternate between the low byte and the high byte, starting low. Low-only and high-only modes always return their one byte.
- R11: A control word with nonzero access mode restarts both the write and the read byte order of its channel at the low byte.
- R12: A read of address 3 returns 0 and changes no state.
- R13: After reset every channel is in low-then-high mode, counting mode 0, binary, with null-count set, no latches, no strobe and `loadCount` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 write, 0 read |
| busAddr | input | 2 | 0..2 channel data port, 3 control port |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte, valid while a read is presented |
| liveCount | input | 48 | Live count of each channel, channel 0 in bits 15:0 |
| liveOut | input | 3 | Live output level of each channel |
| loadStb | output | 3 | One-cycle load strobe per channel |
| loadCount | output | 48 | Count to load, channel 0 in bits 15:0 |
| chanMode | output | 9 | Counting mode per channel, 3 bits each |
| chanBcd | output | 3 | BCD flag per channel |

## Verification
A read-back command with both latch bits low captures the status snapshot and the count snapshot of a channel at the same edge. Each snapshot then competes for the data port. The bench issues such combined commands, both in directed form and at random, and changes the live count right after. It checks that the status byte comes out first, then the captured (not the current) count bytes in access-mode order, and then live bytes. Random reprogramming while latches are still pending is also checked against a bench model, to confirm that an old snapshot survives a new control word.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_CH = 3;
  localparam int MODE_W = 3;

  // Access mode code; in a latch state register, ACC_ZERO means empty
  typedef enum logic [1:0] {
    ACC_ZERO = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_LOHI = 2'd3
  } accMode_t;

  // Strobes from bus decode to the channel datapath
  typedef struct packed {
    logic [NUM_CH-1:0] progCh;
    logic [NUM_CH-1:0] latchCnt;
    logic [NUM_CH-1:0] latchSts;
    logic [NUM_CH-1:0] wrCh;
    logic [NUM_CH-1:0] rdCh;
    logic [BYTE_W-1:0] byteVal;
    accMode_t          acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctlStb_t;
endpackage

// File: rtl/tmr_bus_ctl.sv
module tmr_bus_ctl
  import tmr_bus_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output ctlStb_t           stb
);
  localparam logic [1:0] CTL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL   = 2'd3;

  logic             isCtl;
  logic [1:0]       selField;
  accMode_t         accField;
  logic [MODE_W-1:0] modeRaw;
  logic             rbNoCount;
  logic             rbNoStatus;

  assign isCtl      = busSel && busWr && (busAddr == CTL_ADDR);
  assign selField   = busWdata[7:6];
  assign accField   = accMode_t'(busWdata[5:4]);
  assign modeRaw    = busWdata[3:1];
  assign rbNoCount  = busWdata[5];
  assign rbNoStatus = busWdata[4];

  always_comb begin
    stb         = '0;
    stb.byteVal = busWdata;
    stb.acc     = accField;
    // modes 6 and 7 alias onto 2 and 3
    stb.mode    = (modeRaw[2] && modeRaw[1]) ? {1'b0, modeRaw[1:0]} : modeRaw;
    stb.bcd     = busWdata[0];
    for (int c = 0; c < NUM_CH; c++) begin
      stb.progCh[c]   = isCtl && (selField == 2'(c)) && (accField != ACC_ZERO);
      stb.latchCnt[c] = isCtl &&
                        (((selField == 2'(c)) && (accField == ACC_ZERO)) ||
                         ((selField == RB_SEL) && busWdata[c+1] && !rbNoCount));
      stb.latchSts[c] = isCtl && (selField == RB_SEL) && busWdata[c+1] && !rbNoStatus;
      stb.wrCh[c]     = busSel && busWr  && (busAddr == 2'(c));
      stb.rdCh[c]     = busSel && !busWr && (busAddr == 2'(c));
    end
  end
endmodule

// File: rtl/tmr_bus_dp.sv
module tmr_bus_dp
  import tmr_bus_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStb_t                  stb,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        liveOut,
  output logic [BYTE_W-1:0]        rdByte,
  output logic [NUM_CH-1:0]        loadStb,
  output logic [NUM_CH*CNT_W-1:0]  loadCount,
  output logic [NUM_CH*MODE_W-1:0] chanMode,
  output logic [NUM_CH-1:0]        chanBcd
);
  logic [BYTE_W-1:0] chByte [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    accMode_t          accReg;
    logic [MODE_W-1:0] modeReg;
    logic              bcdReg;
    logic              wrHi;
    logic              rdHi;
    logic [BYTE_W-1:0] wrLo;
    accMode_t          cntLat;
    logic [CNT_W-1:0]  cntSnap;
    logic              stsLat;
    logic [BYTE_W-1:0] stsSnap;
    logic              nullCnt;
    logic              ldStb;
    logic [CNT_W-1:0]  ldVal;
    logic [CNT_W-1:0]  live;

    assign live = liveCount[c*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accReg  <= ACC_LOHI;
        modeReg <= '0;
        bcdReg  <= 1'b0;
        wrHi    <= 1'b0;
        rdHi    <= 1'b0;
        wrLo    <= '0;
        cntLat  <= ACC_ZERO;
        cntSnap <= '0;
        stsLat  <= 1'b0;
        stsSnap <= '0;
        nullCnt <= 1'b1;
        ldStb   <= 1'b0;
        ldVal   <= '0;
      end else begin
        ldStb <= 1'b0;
        if (stb.progCh[c]) begin
          accReg  <= stb.acc;
          modeReg <= stb.mode;
          bcdReg  <= stb.bcd;
          wrHi    <= 1'b0;
          rdHi    <= 1'b0;
          nullCnt <= 1'b1;
        end
        if (stb.latchCnt[c] && (cntLat == ACC_ZERO)) begin
          cntLat  <= accReg;
          cntSnap <= live;
        end
        if (stb.latchSts[c] && !stsLat) begin
          stsLat  <= 1'b1;
          stsSnap <= {liveOut[c], nullCnt, accReg, modeReg, bcdReg};
        end
        if (stb.wrCh[c]) begin
          unique case (accReg)
            ACC_LO: begin
              ldStb   <= 1'b1;
              ldVal   <= {{BYTE_W{1'b0}}, stb.byteVal};
              nullCnt <= 1'b0;
            end
            ACC_HI: begin
              ldStb   <= 1'b1;
              ldVal   <= {stb.byteVal, {BYTE_W{1'b0}}};
              nullCnt <= 1'b0;
            end
            default: begin
              if (!wrHi) begin
                wrLo <= stb.byteVal;
                wrHi <= 1'b1;
              end else begin
                ldStb   <= 1'b1;
                ldVal   <= {stb.byteVal, wrLo};
                wrHi    <= 1'b0;
                nullCnt <= 1'b0;
              end
            end
          endcase
        end
        if (stb.rdCh[c]) begin
          if (stsLat) begin
            stsLat <= 1'b0;
          end else if (cntLat != ACC_ZERO) begin
            cntLat <= (cntLat == ACC_LOHI) ? ACC_HI : ACC_ZERO;
          end else if (accReg == ACC_LOHI) begin
            rdHi <= !rdHi;
          end
        end
      end
    end

    always_comb begin
      if (stsLat) begin
        chByte[c] = stsSnap;
      end else if (cntLat != ACC_ZERO) begin
        chByte[c] = (cntLat == ACC_HI) ? cntSnap[CNT_W-1:BYTE_W] : cntSnap[BYTE_W-1:0];
      end else if ((accReg == ACC_HI) || ((accReg == ACC_LOHI) && rdHi)) begin
        chByte[c] = live[CNT_W-1:BYTE_W];
      end else begin
        chByte[c] = live[BYTE_W-1:0];
      end
    end

    assign loadStb[c]                     = ldStb;
    assign loadCount[c*CNT_W +: CNT_W]    = ldVal;
    assign chanMode[c*MODE_W +: MODE_W]   = modeReg;
    assign chanBcd[c]                     = bcdReg;
  end

  always_comb begin
    rdByte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (stb.rdCh[c]) rdByte = rdByte | chByte[c];
    end
  end
endmodule

// File: rtl/tmr_bus_front.sv
module tmr_bus_front
  import tmr_bus_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [1:0]               busAddr,
  input  logic [BYTE_W-1:0]        busWdata,
  output logic [BYTE_W-1:0]        busRdata,
  input  logic [NUM_CH*CNT_W-1:0]  liveCount,
  input  logic [NUM_CH-1:0]        liveOut,
  output logic [NUM_CH-1:0]        loadStb,
  output logic [NUM_CH*CNT_W-1:0]  loadCount,
  output logic [NUM_CH*MODE_W-1:0] chanMode,
  output logic [NUM_CH-1:0]        chanBcd
);
  ctlStb_t stb;

  tmr_bus_ctl uCtl (
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  tmr_bus_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .liveCount (liveCount),
    .liveOut   (liveOut),
    .rdByte    (busRdata),
    .loadStb   (loadStb),
    .loadCount (loadCount),
    .chanMode  (chanMode),
    .chanBcd   (chanBcd)
  );
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk
  import tmr_bus_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     busSel,
  input logic                     busWr,
  input logic [1:0]               busAddr,
  input logic [BYTE_W-1:0]        busRdata,
  input logic [NUM_CH-1:0]        loadStb,
  input logic [NUM_CH*CNT_W-1:0]  loadCount,
  input logic [NUM_CH*MODE_W-1:0] chanMode
);
  // R4
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStb));

  // R12
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd3) |-> (busRdata == '0));

  // R12
  ctl_read_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd3) |=> (loadStb == '0));

  // R13
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb == '0) |-> $stable(loadCount));

  for (genvar c = 0; c < NUM_CH; c++) begin : gChk
    // R2
    load_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      loadStb[c] |-> $past(busSel && busWr && (busAddr == 2'(c))));

    // R1
    mode_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanMode[c*MODE_W +: MODE_W] <= 3'd5);
  end
endmodule

bind tmr_bus_front tmr_bus_front_chk uChk (.*);

// File: tb/tmr_bus_front_test.sv
module tmr_bus_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [47:0] liveCount = '0;
  logic [2:0]  liveOut = '0;
  logic [2:0]  loadStb;
  logic [47:0] loadCount;
  logic [8:0]  chanMode;
  logic [2:0]  chanBcd;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_bus_front uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .liveCount(liveCount),
    .liveOut(liveOut), .loadStb(loadStb), .loadCount(loadCount),
    .chanMode(chanMode), .chanBcd(chanBcd)
  );

  // bench model state per channel
  logic [1:0]  mAcc [3];
  logic [2:0]  mMode [3];
  logic        mBcd [3];
  logic        mWrHi [3];
  logic        mRdHi [3];
  logic [7:0]  mWrLo [3];
  logic [1:0]  mCntL [3];
  logic [15:0] mLatch [3];
  logic        mStsL [3];
  logic [7:0]  mSts [3];
  logic        mNull [3];

  logic [7:0]  lastRd;
  logic [2:0]  lastMask;
  logic [15:0] lastVal;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelInit();
    for (int c = 0; c < 3; c++) begin
      mAcc[c] = 2'd3; mMode[c] = 3'd0; mBcd[c] = 1'b0; mWrHi[c] = 1'b0;
      mRdHi[c] = 1'b0; mWrLo[c] = 8'h00; mCntL[c] = 2'd0; mLatch[c] = 16'h0;
      mStsL[c] = 1'b0; mSts[c] = 8'h00; mNull[c] = 1'b1;
    end
  endtask

  function automatic logic [15:0] liveOf(input int c);
    return liveCount[c*16 +: 16];
  endfunction

  task automatic modelLatchCnt(input int c);
    if (mCntL[c] == 2'd0) begin
      mCntL[c] = mAcc[c];
      mLatch[c] = liveOf(c);
    end
  endtask

  task automatic modelOp(input bit wr, input logic [1:0] a, input logic [7:0] d,
                         output logic [2:0] eMask, output logic [15:0] eVal,
                         output logic [7:0] eRd);
    int c;
    logic [2:0] m;
    eMask = 3'b000; eVal = 16'h0; eRd = 8'h00;
    c = int'(a);
    if (wr && a == 2'd3) begin
      if (d[7:6] == 2'd3) begin
        for (int k = 0; k < 3; k++) begin
          if (d[k+1]) begin
            if (!d[5]) modelLatchCnt(k);
            if (!d[4] && !mStsL[k]) begin
              mStsL[k] = 1'b1;
              mSts[k] = {liveOut[k], mNull[k], mAcc[k], mMode[k], mBcd[k]};
            end
          end
        end
      end else if (d[5:4] == 2'd0) begin
        modelLatchCnt(int'(d[7:6]));
      end else begin
        c = int'(d[7:6]);
        m = d[3:1];
        if (m > 3'd5) m = m - 3'd4;
        mAcc[c] = d[5:4]; mMode[c] = m; mBcd[c] = d[0];
        mWrHi[c] = 1'b0; mRdHi[c] = 1'b0; mNull[c] = 1'b1;
      end
    end else if (wr) begin
      if (mAcc[c] == 2'd1) begin
        eMask = 3'b001 << c; eVal = {8'h00, d}; mNull[c] = 1'b0;
      end else if (mAcc[c] == 2'd2) begin
        eMask = 3'b001 << c; eVal = {d, 8'h00}; mNull[c] = 1'b0;
      end else if (!mWrHi[c]) begin
        mWrLo[c] = d; mWrHi[c] = 1'b1;
      end else begin
        eMask = 3'b001 << c; eVal = {d, mWrLo[c]}; mWrHi[c] = 1'b0; mNull[c] = 1'b0;
      end
    end else if (a != 2'd3) begin
      if (mStsL[c]) begin
        eRd = mSts[c]; mStsL[c] = 1'b0;
      end else if (mCntL[c] != 2'd0) begin
        if (mCntL[c] == 2'd2) begin
          eRd = mLatch[c][15:8]; mCntL[c] = 2'd0;
        end else if (mCntL[c] == 2'd1) begin
          eRd = mLatch[c][7:0]; mCntL[c] = 2'd0;
        end else begin
          eRd = mLatch[c][7:0]; mCntL[c] = 2'd2;
        end
      end else begin
        if (mAcc[c] == 2'd2 || (mAcc[c] == 2'd3 && mRdHi[c])) eRd = liveOf(c)[15:8];
        else eRd = liveOf(c)[7:0];
        if (mAcc[c] == 2'd3) mRdHi[c] = !mRdHi[c];
      end
    end
  endtask

  task automatic doOp(input bit wr, input logic [1:0] a, input logic [7:0] d, input string tag);
    logic [2:0]  eMask;
    logic [15:0] eVal;
    logic [7:0]  eRd;
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = d;
    modelOp(wr, a, d, eMask, eVal, eRd);
    #1;
    lastRd = busRdata;
    @(negedge clk);
    busSel = 1'b0;
    lastMask = loadStb;
    lastVal = 16'h0;
    for (int c = 0; c < 3; c++) if (loadStb[c]) lastVal = loadCount[c*16 +: 16];
    if (!wr) chk(lastRd == eRd, {tag, " read byte"}, lastRd, eRd);
    chk(lastMask == eMask, {tag, " load strobe"}, lastMask, eMask);
    if (eMask != 3'b000) chk(lastVal == eVal, {tag, " load value"}, lastVal, eVal);
    if (wr && a == 2'd3) begin
      for (int c = 0; c < 3; c++) begin
        chk(chanMode[c*3 +: 3] == mMode[c], "R1 mode output", chanMode[c*3 +: 3], mMode[c]);
        chk(chanBcd[c] == mBcd[c], "R1 bcd output", chanBcd[c], mBcd[c]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    modelInit();
    liveCount = {16'h2222, 16'h1111, 16'hBEEF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(loadStb == 3'b000, "R13 strobe idle", loadStb, 0);
    chk(loadCount == 48'h0, "R13 load count zero", loadCount[15:0], 0);
    chk(chanMode == 9'h0 && chanBcd == 3'b000, "R13 mode and bcd", chanMode, 0);
    doOp(0, 2'd3, 8'h00, "R12");
    chk(lastRd == 8'h00, "R12 control read", lastRd, 0);
    doOp(0, 2'd0, 8'h00, "R13");
    chk(lastRd == 8'hEF, "R13 lohi live low", lastRd, 8'hEF);
    doOp(0, 2'd0, 8'h00, "R13");

    // R1 decode with mode folding
    doOp(1, 2'd3, 8'h5F, "R1");
    chk(chanMode[5:3] == 3'd3 && chanBcd[1], "R1 fold 7 to 3", chanMode[5:3], 3);
    // R2
    doOp(1, 2'd1, 8'h5A, "R2");
    chk(lastMask == 3'b010 && lastVal == 16'h005A, "R2 low only load", lastVal, 16'h005A);
    // R3
    doOp(1, 2'd3, 8'hA4, "R1");
    doOp(1, 2'd2, 8'h34, "R3");
    chk(lastMask == 3'b100 && lastVal == 16'h3400, "R3 high only load", lastVal, 16'h3400);
    // R4
    doOp(1, 2'd3, 8'h36, "R1");
    doOp(1, 2'd0, 8'h11, "R4");
    chk(lastMask == 3'b000, "R4 first byte no load", lastMask, 0);
    doOp(1, 2'd0, 8'h22, "R4");
    chk(lastMask == 3'b001 && lastVal == 16'h2211, "R4 second byte load", lastVal, 16'h2211);

    // R5 R6 latch then stale request
    doOp(1, 2'd3, 8'h00, "R5");
    liveCount[15:0] = 16'h1234;
    doOp(1, 2'd3, 8'h00, "R6");
    doOp(0, 2'd0, 8'h00, "R5");
    chk(lastRd == 8'hEF, "R5 latched low", lastRd, 8'hEF);
    doOp(0, 2'd0, 8'h00, "R6");
    chk(lastRd == 8'hBE, "R6 second latch ignored", lastRd, 8'hBE);
    doOp(0, 2'd0, 8'h00, "R10");
    chk(lastRd == 8'h34, "R10 live low", lastRd, 8'h34);
    doOp(0, 2'd0, 8'h00, "R10");
    chk(lastRd == 8'h12, "R10 live high", lastRd, 8'h12);

    // R7 R8 R9 combined read-back
    liveCount[15:0] = 16'h5678;
    liveOut = 3'b001;
    doOp(1, 2'd3, 8'hC2, "R7");
    liveCount[15:0] = 16'h9999;
    doOp(0, 2'd0, 8'h00, "R8");
    chk(lastRd == 8'hB6, "R8 status layout", lastRd, 8'hB6);
    doOp(0, 2'd0, 8'h00, "R9");
    chk(lastRd == 8'h78, "R9 count after status", lastRd, 8'h78);
    doOp(0, 2'd0, 8'h00, "R9");
    chk(lastRd == 8'h56, "R9 count high", lastRd, 8'h56);
    doOp(0, 2'd0, 8'h00, "R9");
    chk(lastRd == 8'h99, "R9 live after latches", lastRd, 8'h99);

    // R7 multi-channel count read-back
    liveCount[47:16] = {16'hC3D4, 16'hA1B2};
    doOp(1, 2'd3, 8'hDC, "R7");
    liveCount[47:16] = 32'h0;
    doOp(0, 2'd1, 8'h00, "R7");
    chk(lastRd == 8'hB2, "R7 channel 1 latched", lastRd, 8'hB2);
    doOp(0, 2'd2, 8'h00, "R7");
    chk(lastRd == 8'hC3, "R7 channel 2 latched", lastRd, 8'hC3);

    // R11 sequencing restart (read state is at high after one live read)
    doOp(1, 2'd0, 8'h77, "R11");
    doOp(1, 2'd3, 8'h36, "R11");
    doOp(1, 2'd0, 8'hAA, "R11");
    chk(lastMask == 3'b000, "R11 write order restarted", lastMask, 0);
    doOp(1, 2'd0, 8'hBB, "R11");
    chk(lastVal == 16'hBBAA, "R11 load after restart", lastVal, 16'hBBAA);
    doOp(0, 2'd0, 8'h00, "R11");
    doOp(1, 2'd3, 8'h36, "R11");
    liveCount[15:0] = 16'h4321;
    doOp(0, 2'd0, 8'h00, "R11");
    chk(lastRd == 8'h21, "R11 read order restarted", lastRd, 8'h21);

    // R8 null count, R12 no side effect
    liveOut = 3'b000;
    doOp(1, 2'd3, 8'h36, "R8");
    doOp(1, 2'd0, 8'h01, "R8");
    doOp(1, 2'd3, 8'hE2, "R8");
    doOp(0, 2'd3, 8'h00, "R12");
    doOp(0, 2'd0, 8'h00, "R12");
    chk(lastRd == 8'h76, "R12 status kept across control read, null set", lastRd, 8'h76);
    doOp(1, 2'd0, 8'h02, "R8");
    doOp(1, 2'd3, 8'hE2, "R8");
    doOp(0, 2'd0, 8'h00, "R8");
    chk(lastRd == 8'h36, "R8 null cleared by load", lastRd, 8'h36);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [1:0] a;
      logic [7:0] d;
      liveCount = {$urandom, $urandom};
      liveOut = 3'($urandom);
      kind = $urandom_range(0, 9);
      d = 8'($urandom);
      if (kind < 3) begin
        if (kind == 0) d[7:6] = 2'd3;
        doOp(1, 2'd3, d, "R1");
      end else if (kind < 6) begin
        a = 2'($urandom_range(0, 2));
        doOp(1, a, d, "R4");
      end else begin
        a = 2'($urandom);
        doOp(0, a, 8'h00, "R9");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule